// File: doc/BRIEF.md
# DMA Peripheral Request/Acknowledge Handshake Unit

This block is the peripheral-facing handshake stage of a single DMA channel. It watches eight asynchronous request lines, picks one of them with a select field from the channel control word, and tells the transfer engine through a pending flag that a transfer is wanted. The request may be sensed as a level or as an edge, and each polarity (high/rising and low/falling) has its own enable.

When the engine performs a beat on the side chosen to carry the handshake (the read side or the write side), the block answers on the acknowledge line of the selected set. The answer is a one-clock pulse, a level held while the request stays active, or nothing at all. When the engine flags that the beat moves the final unit, a one-clock terminal-count pulse goes out on the selected set unless it is masked. All lines of the sets that are not selected stay low.

Top module: `dmahs_unit`

## Requirements
- R1: Acknowledge and terminal-count outputs are only ever driven on the line whose index equals the select field; all other bits of both vectors stay 0.
- R2: In level mode (level bit = 1) the pending flag is 1 when the selected synchronized request is high with the high enable set, or low with the low enable set; a change on a request input reaches the pending flag two clocks after it is sampled.
- R3: In edge mode (level bit = 0) a rising edge on the selected synchronized request with the high enable set, or a falling edge with the low enable set, sets a sticky pending flag one clock after the edge is seen; an edge whose polarity enable is clear is ignored.
- R4: In edge mode the sticky pending flag clears on a beat of the handshake side; a qualifying edge in the same cycle keeps it set.
- R5: With acknowledge mode 00 the selected acknowledge is high for exactly the clock after each handshake-side beat.
- R6: With acknowledge mode 01 the selected acknowledge rises the clock after a handshake-side beat and stays high for as long as the selected request remains active in the sense of R2, falling the clock after it becomes inactive.
- R7: With acknowledge mode 10 or 11 no acknowledge line is ever driven.
- R8: With the side bit = 0 only the read-beat strobe is the handshake beat; with the side bit = 1 only the write-beat strobe is; the other strobe has no effect on acknowledge, terminal count or the pending flag.
- R9: A handshake-side beat with the final-unit flag high produces a one-clock terminal-count pulse on the selected line the following clock, unless the terminal-count mask bit is 1, in which case no terminal count is driven.
- R10: During and directly after reset the pending flag (in edge mode), all acknowledge lines and all terminal-count lines are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 8 | Peripheral request lines, asynchronous |
| cfg_sel | input | 3 | Index of the request/acknowledge/terminal-count set in use |
| cfg_level | input | 1 | 1 = level sensing, 0 = edge sensing |
| cfg_hi_en | input | 1 | Accept high level / rising edge |
| cfg_lo_en | input | 1 | Accept low level / falling edge |
| cfg_ack_mode | input | 2 | 00 pulse, 01 level, 1x suppressed |
| cfg_dst_side | input | 1 | 0 = handshake on read beat, 1 = on write beat |
| cfg_tc_mask | input | 1 | 1 = terminal-count output forced low |
| rd_beat_i | input | 1 | Read beat strobe from the transfer engine |
| wr_beat_i | input | 1 | Write beat strobe from the transfer engine |
| last_unit_i | input | 1 | Current beat moves the final unit |
| req_pend_o | output | 1 | Transfer request pending to the engine |
| ack_o | output | 8 | Acknowledge lines |
| tc_o | output | 8 | Terminal-count lines |

## Verification
The assertions assume that the configuration fields and the beat and final-unit strobes are synchronous to the clock, while the request lines may change at any time. Checks that relate an acknowledge to the selected index hold only across cycles in which the select field has not moved, so the stimulus changes configuration only between runs, after a quiet stretch with the request lines low and no beats. Within a run the request lines, beats and final-unit flag change randomly each cycle, which includes beats arriving with no request pending and edges coinciding with beats.

// File: rtl/dmahs_pkg.sv
package dmahs_pkg;

  typedef enum logic [1:0] {
    ACK_PULSE = 2'b00,
    ACK_LEVEL = 2'b01,
    ACK_OFF0  = 2'b10,
    ACK_OFF1  = 2'b11
  } ack_mode_e;

endpackage

// File: rtl/dmahs_sync.sv
module dmahs_sync #(
  parameter int N      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o,
  output logic [N-1:0] q_prev_o
);

  logic [N-1:0] stg [STAGES];
  logic [N-1:0] prev_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [N-1:0] stg_d;
    if (g == 0) begin : g_first
      assign stg_d = d_i;
    end else begin : g_chain
      assign stg_d = stg[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[g] <= '0;
      else        stg[g] <= stg_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= stg[STAGES-1];
  end

  assign q_o      = stg[STAGES-1];
  assign q_prev_o = prev_q;

endmodule

// File: rtl/dmahs_detect.sv
module dmahs_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic cur_i,
  input  logic prev_i,
  input  logic cfg_level,
  input  logic cfg_hi_en,
  input  logic cfg_lo_en,
  input  logic beat_i,
  output logic active_o,
  output logic pend_o
);

  logic active;
  logic rise_hit, fall_hit, edge_hit;
  logic flag_q, flag_d, flag_en;

  always_comb begin
    active   = (cfg_hi_en & cur_i) | (cfg_lo_en & ~cur_i);
    rise_hit = cfg_hi_en & cur_i & ~prev_i;
    fall_hit = cfg_lo_en & ~cur_i & prev_i;
    edge_hit = ~cfg_level & (rise_hit | fall_hit);
  end

  always_comb begin
    flag_en = 1'b0;
    flag_d  = flag_q;
    if (cfg_level) begin
      flag_en = flag_q;
      flag_d  = 1'b0;
    end else if (edge_hit) begin
      flag_en = 1'b1;
      flag_d  = 1'b1;
    end else if (beat_i) begin
      flag_en = 1'b1;
      flag_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  assign active_o = active;
  assign pend_o   = cfg_level ? active : flag_q;

  // R3
  edge_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(edge_hit) && !cfg_level) |-> pend_o);

  // R4
  beat_clears_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(beat_i) && !$past(edge_hit) && !$past(cfg_level) && !cfg_level) |-> !pend_o);

endmodule

// File: rtl/dmahs_ack.sv
module dmahs_ack
  import dmahs_pkg::*;
#(
  parameter int N     = 8,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [1:0]       mode_i,
  input  logic             dst_side_i,
  input  logic             tc_mask_i,
  input  logic             rd_beat_i,
  input  logic             wr_beat_i,
  input  logic             last_unit_i,
  input  logic             active_i,
  output logic             beat_o,
  output logic [N-1:0]     ack_o,
  output logic [N-1:0]     tc_o
);

  logic         beat;
  logic         ack_bit, tc_bit;
  logic [N-1:0] ack_q, ack_d;
  logic [N-1:0] tc_q, tc_d;
  ack_mode_e    mode;

  assign mode = ack_mode_e'(mode_i);
  assign beat = dst_side_i ? wr_beat_i : rd_beat_i;

  always_comb begin
    unique case (mode)
      ACK_PULSE: ack_bit = beat;
      ACK_LEVEL: ack_bit = (beat | ack_q[sel_i]) & active_i;
      default:   ack_bit = 1'b0;
    endcase
    tc_bit = beat & last_unit_i & ~tc_mask_i;
  end

  for (genvar i = 0; i < N; i++) begin : g_line
    always_comb begin
      ack_d[i] = (sel_i == SEL_W'(i)) ? ack_bit : 1'b0;
      tc_d[i]  = (sel_i == SEL_W'(i)) ? tc_bit  : 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q <= '0;
      tc_q  <= '0;
    end else begin
      ack_q <= ack_d;
      tc_q  <= tc_d;
    end
  end

  assign beat_o = beat;
  assign ack_o  = ack_q;
  assign tc_o   = tc_q;

  // R1
  ack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack_q) && $onehot0(tc_q));

  // R1
  ack_on_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|ack_q) && $stable(sel_i)) |-> ack_q[sel_i]);

  // R5
  pulse_follows_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|ack_q) && ($past(mode_i) == 2'b00)) |-> $past(beat));

  // R6
  level_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_i == 2'b01) && $stable(mode_i) && $stable(sel_i) && $past(ack_q[sel_i])
      && $past(active_i)) |-> ack_q[sel_i]);

  // R7
  ack_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mode_i[1]) |-> (ack_q == '0));

  // R8
  side_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|ack_q) && ($past(mode_i) == 2'b00) && $past(dst_side_i)) |-> $past(wr_beat_i));

  // R9
  tc_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(tc_mask_i) |-> (tc_q == '0));

  // R9
  tc_needs_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|tc_q) |-> ($past(last_unit_i) && $past(beat)));

endmodule

// File: rtl/dmahs_unit.sv
module dmahs_unit #(
  parameter  int NUM_LINES   = 8,
  parameter  int SYNC_STAGES = 2,
  localparam int SEL_W       = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] req_i,
  input  logic [SEL_W-1:0]     cfg_sel,
  input  logic                 cfg_level,
  input  logic                 cfg_hi_en,
  input  logic                 cfg_lo_en,
  input  logic [1:0]           cfg_ack_mode,
  input  logic                 cfg_dst_side,
  input  logic                 cfg_tc_mask,
  input  logic                 rd_beat_i,
  input  logic                 wr_beat_i,
  input  logic                 last_unit_i,
  output logic                 req_pend_o,
  output logic [NUM_LINES-1:0] ack_o,
  output logic [NUM_LINES-1:0] tc_o
);

  logic [NUM_LINES-1:0] req_sync, req_prev;
  logic                 sel_cur, sel_prev;
  logic                 active, beat;

  dmahs_sync #(.N(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .d_i      (req_i),
    .q_o      (req_sync),
    .q_prev_o (req_prev)
  );

  assign sel_cur  = req_sync[cfg_sel];
  assign sel_prev = req_prev[cfg_sel];

  dmahs_detect u_detect (
    .clk       (clk),
    .rst_n     (rst_n),
    .cur_i     (sel_cur),
    .prev_i    (sel_prev),
    .cfg_level (cfg_level),
    .cfg_hi_en (cfg_hi_en),
    .cfg_lo_en (cfg_lo_en),
    .beat_i    (beat),
    .active_o  (active),
    .pend_o    (req_pend_o)
  );

  dmahs_ack #(.N(NUM_LINES), .SEL_W(SEL_W)) u_ack (
    .clk         (clk),
    .rst_n       (rst_n),
    .sel_i       (cfg_sel),
    .mode_i      (cfg_ack_mode),
    .dst_side_i  (cfg_dst_side),
    .tc_mask_i   (cfg_tc_mask),
    .rd_beat_i   (rd_beat_i),
    .wr_beat_i   (wr_beat_i),
    .last_unit_i (last_unit_i),
    .active_i    (active),
    .beat_o      (beat),
    .ack_o       (ack_o),
    .tc_o        (tc_o)
  );

  // R10
  reset_quiet_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> ((ack_o == '0) && (tc_o == '0)));

endmodule

// File: tb/dmahs_unit_tb.sv
`timescale 1ns/1ps
module dmahs_unit_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] req_i;
  logic [2:0] cfg_sel;
  logic       cfg_level, cfg_hi_en, cfg_lo_en;
  logic [1:0] cfg_ack_mode;
  logic       cfg_dst_side, cfg_tc_mask;
  logic       rd_beat_i, wr_beat_i, last_unit_i;
  logic       req_pend_o;
  logic [7:0] ack_o, tc_o;

  int checks   = 0;
  int failures = 0;

  // reference state
  logic [7:0] hist[$];
  bit         m_flag;
  logic [7:0] m_ack, m_tc;
  bit         m_pend;

  always #4 clk = ~clk;

  dmahs_unit u_dut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .cfg_sel(cfg_sel),
    .cfg_level(cfg_level), .cfg_hi_en(cfg_hi_en), .cfg_lo_en(cfg_lo_en),
    .cfg_ack_mode(cfg_ack_mode), .cfg_dst_side(cfg_dst_side),
    .cfg_tc_mask(cfg_tc_mask), .rd_beat_i(rd_beat_i), .wr_beat_i(wr_beat_i),
    .last_unit_i(last_unit_i), .req_pend_o(req_pend_o), .ack_o(ack_o), .tc_o(tc_o)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit is_active(input logic [7:0] v);
    return (cfg_hi_en && v[cfg_sel]) || (cfg_lo_en && !v[cfg_sel]);
  endfunction

  task automatic model_reset();
    hist = {8'h00, 8'h00, 8'h00};
    m_flag = 0; m_ack = 0; m_tc = 0;
  endtask

  // advance the reference by one clock edge with the inputs now applied
  task automatic model_step();
    logic [7:0] older, cur;
    bit v, p, beat, act, edg, nb;
    older = hist[0];
    cur   = hist[1];
    v = cur[cfg_sel];
    p = older[cfg_sel];
    beat = cfg_dst_side ? wr_beat_i : rd_beat_i;
    act  = is_active(cur);
    edg  = !cfg_level && ((cfg_hi_en && v && !p) || (cfg_lo_en && !v && p));
    if (cfg_level)  m_flag = 0;
    else if (edg)   m_flag = 1;
    else if (beat)  m_flag = 0;
    case (cfg_ack_mode)
      2'b00:   nb = beat;
      2'b01:   nb = (beat || m_ack[cfg_sel]) && act;
      default: nb = 0;
    endcase
    m_ack = 8'(nb) << cfg_sel;
    m_tc  = 8'(beat && last_unit_i && !cfg_tc_mask) << cfg_sel;
    hist.push_back(req_i);
    void'(hist.pop_front());
    m_pend = cfg_level ? is_active(hist[1]) : m_flag;
  endtask

  task automatic run(input int n, input string ptag, input string atag,
                     input int req_chg, input bit quiet);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (quiet) begin
        req_i = 0; rd_beat_i = 0; wr_beat_i = 0; last_unit_i = 0;
      end else begin
        for (int b = 0; b < 8; b++)
          if (($urandom % 100) < req_chg) req_i[b] = ~req_i[b];
        rd_beat_i   = ($urandom % 3) == 0;
        wr_beat_i   = ($urandom % 3) == 0;
        last_unit_i = ($urandom % 4) == 0;
      end
      @(posedge clk);
      #1;
      model_step();
      check(ptag, {7'd0, req_pend_o}, {7'd0, m_pend});
      check(atag, ack_o, m_ack);
      check("R9 tc", tc_o, m_tc);
      // R1: lines other than the selected one stay quiet
      check("R1 unselected", (ack_o | tc_o) & ~(8'd1 << cfg_sel), 8'd0);
    end
  endtask

  task automatic set_cfg(input logic [2:0] sel, input bit lvl, input bit hi, input bit lo,
                         input logic [1:0] mode, input bit dst, input bit mask);
    @(negedge clk);
    cfg_sel = sel; cfg_level = lvl; cfg_hi_en = hi; cfg_lo_en = lo;
    cfg_ack_mode = mode; cfg_dst_side = dst; cfg_tc_mask = mask;
  endtask

  initial begin
    #(8 * 150000);
    failures++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 0; req_i = 0; rd_beat_i = 0; wr_beat_i = 0; last_unit_i = 0;
    cfg_sel = 3'd2; cfg_level = 0; cfg_hi_en = 1; cfg_lo_en = 0;
    cfg_ack_mode = 2'b00; cfg_dst_side = 0; cfg_tc_mask = 0;
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    check("R10 pend", {7'd0, req_pend_o}, 8'd0);
    check("R10 ack", ack_o, 8'd0);
    check("R10 tc", tc_o, 8'd0);
    @(negedge clk);
    rst_n = 1;
    #1;
    check("R10 ack after release", ack_o | tc_o, 8'd0);

    // rising edges, pulse ack on read side
    run(400, "R3 R4 pend", "R5 ack", 20, 0);
    run(8, "R3 R4 pend", "R5 ack", 0, 1);

    // falling edges, level ack on write side
    set_cfg(3'd5, 0, 0, 1, 2'b01, 1, 0);
    run(400, "R3 R4 pend", "R6 R8 ack", 15, 0);
    run(8, "R3 R4 pend", "R6 R8 ack", 0, 1);

    // both edges, pulse on write side
    set_cfg(3'd0, 0, 1, 1, 2'b00, 1, 0);
    run(400, "R3 R4 pend", "R5 R8 ack", 25, 0);
    run(8, "R3 R4 pend", "R5 R8 ack", 0, 1);

    // level sensing both polarities, ack suppressed, tc masked
    set_cfg(3'd7, 1, 1, 1, 2'b10, 0, 1);
    run(300, "R2 pend", "R7 ack", 20, 0);
    run(8, "R2 pend", "R7 ack", 0, 1);

    // level high only, level ack on read side
    set_cfg(3'd3, 1, 1, 0, 2'b01, 0, 0);
    run(400, "R2 pend", "R6 ack", 10, 0);
    run(8, "R2 pend", "R6 ack", 0, 1);

    // edge mode with both enables clear: edges ignored
    set_cfg(3'd1, 0, 0, 0, 2'b11, 1, 0);
    run(300, "R3 ignored pend", "R7 ack", 30, 0);
    run(8, "R3 ignored pend", "R7 ack", 0, 1);

    // level low only, pulse ack read side
    set_cfg(3'd6, 1, 0, 1, 2'b00, 0, 0);
    run(300, "R2 pend", "R5 R8 ack", 20, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule